// File: doc/BRIEF.md
# Single-Slope PWM Timer with Two Compare Channels

This block is an 8-bit up-counter that drives two pulse-width-modulated outputs, channel A and channel B. The counter runs from zero up to a top value and then drops back to zero, so each period is a single rising ramp. The counter only moves on a timer tick. A prescaler makes that tick by dividing the system clock by 1, 8, 32, 64, 128, 256 or 1024, or it stops the counter.

The top value is either the fixed maximum 0xFF or the active compare value of channel A. Each channel compares the counter against its own active compare value. Depending on its 2-bit output mode, the channel clears, sets or toggles its output on a match, and sets or clears it when the counter wraps. Software writes compare values into buffers. These buffers are copied into the active compare registers only when the counter wraps, so each waveform period uses one consistent compare value. A sticky overflow flag marks every tick on which the counter arrives at its top value.

All configuration goes through a small write port: an address, a byte of data and a write strobe.

Top module: `pwm8_timer`

## Requirements
- R1: After reset the counter, both outputs, the flag and every register are 0, and clock select 0 keeps the counter stopped. On each tick the counter goes up by one. On a tick where it equals the top value it returns to 0.
- R2: Control bit 3 (address 0) selects the top value: 0 gives 0xFF, 1 gives the active compare value of channel A.
- R3: Control bits [2:0] (address 0) select the tick. Codes 1 to 7 give one tick every 1, 8, 32, 64, 128, 256 or 1024 clocks, and code 0 gives no ticks. A write of a code that differs from the current one restarts the prescale count from zero. A tick in the cycle of that write still follows the old code.
- R4: Output mode 2 (non-inverting): on a tick where the counter equals the top value the output becomes 1. Otherwise, on a tick where the counter equals the active compare value, the output becomes 0. Between ticks the output holds.
- R5: Output mode 3 (inverting) is mode 2 with the output levels swapped: 0 at the wrap and 1 at the match.
- R6: Output mode 1 on channel A inverts the output on every tick where the counter equals the active compare value. With top from channel A and compare 0, the output inverts on every tick. On channel B, mode 1 holds the output at 0.
- R7: Output mode 0 holds the channel output at 0.
- R8: Writes to address 2 (channel A) and address 3 (channel B) go to buffers. A buffer is copied into its active compare register on the tick where the counter wraps from the top value to 0. A wrap in the same cycle as a buffer write copies the old buffer value.
- R9: The overflow flag becomes 1 on every tick whose new counter value equals the top value. It stays 1 until a write to address 4 with data bit 0 set. If a set and a clear happen in the same cycle, the set wins.
- R10: With top 0xFF, clock select 1 and mode 2, an active compare of 0 gives exactly one high cycle in every 256, and an active compare of 0xFF gives a constantly high output.
- R11: Address 1 holds the output modes: bits [1:0] for channel A and bits [3:2] for channel B. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| cnt | output | 8 | Current counter value |
| out_a | output | 1 | Channel A waveform |
| out_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong prescale count shows up quickly. It moves the counter's step cycle on the cnt port within at most one prescale period. A stale or early active compare value does not show until a later point: the output edge lands on the wrong counter value, or the wrap in channel-A-top mode happens at the wrong count. This can be seen only after the next wrap, up to 256 ticks later. Output mode errors and flag priority errors show in the very next cycle after the tick or clear that exposes them, since the waveform register and the flag change on the clock edge that follows.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

    localparam logic [2:0] ADDR_CTRL  = 3'd0;
    localparam logic [2:0] ADDR_MODE  = 3'd1;
    localparam logic [2:0] ADDR_CMP_A = 3'd2;
    localparam logic [2:0] ADDR_CMP_B = 3'd3;
    localparam logic [2:0] ADDR_CLR   = 3'd4;

    localparam logic [1:0] OM_OFF    = 2'd0;
    localparam logic [1:0] OM_TOGGLE = 2'd1;
    localparam logic [1:0] OM_NONINV = 2'd2;
    localparam logic [1:0] OM_INV    = 2'd3;

    localparam int PRE_W = 10;

    function automatic logic [PRE_W-1:0] presc_limit(input logic [2:0] sel);
        logic [PRE_W-1:0] lim;
        case (sel)
            3'd1:    lim = PRE_W'(0);
            3'd2:    lim = PRE_W'(7);
            3'd3:    lim = PRE_W'(31);
            3'd4:    lim = PRE_W'(63);
            3'd5:    lim = PRE_W'(127);
            3'd6:    lim = PRE_W'(255);
            3'd7:    lim = PRE_W'(1023);
            default: lim = PRE_W'(0);
        endcase
        return lim;
    endfunction

    typedef struct packed {
        logic [2:0] sel;
        logic       top_sel;
        logic [1:0] mode_a;
        logic [1:0] mode_b;
        logic [7:0] buf_a;
        logic [7:0] buf_b;
        logic [7:0] act_a;
        logic [7:0] act_b;
        logic       flag;
    } regs_t;

endpackage

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler
    import pwm8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       restart,
    output logic       tick
);
    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        tick  = (sel != 3'd0) && (pre_q == presc_limit(sel));
        pre_d = pre_q;
        if (restart || sel == 3'd0 || tick) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] top_val,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          reach
);
    logic [CW-1:0] cnt_d, cnt_q, step;

    always_comb begin
        wrap  = tick && (cnt_q == top_val);
        step  = (cnt_q == top_val) ? '0 : cnt_q + CW'(1);
        reach = tick && (step == top_val);
        cnt_d = tick ? step : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel
    import pwm8_pkg::*;
#(
    parameter int CW         = 8,
    parameter bit HAS_TOGGLE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wrap,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic [1:0]    mode,
    output logic          wave
);
    logic wave_d, wave_q, match;

    always_comb begin
        match  = tick && (cnt == cmp);
        wave_d = wave_q;
        case (mode)
            OM_OFF:    wave_d = 1'b0;
            OM_TOGGLE: begin
                if (HAS_TOGGLE) wave_d = match ? ~wave_q : wave_q;
                else            wave_d = 1'b0;
            end
            OM_NONINV: begin
                if (wrap)       wave_d = 1'b1;
                else if (match) wave_d = 1'b0;
            end
            default: begin
                if (wrap)       wave_d = 1'b0;
                else if (match) wave_d = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    assign wave = wave_q;
endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
    import pwm8_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [7:0]    wr_data,
    output logic [CW-1:0] cnt,
    output logic          out_a,
    output logic          out_b,
    output logic          ovf_flag
);
    localparam logic [CW-1:0] MAX_VAL = {CW{1'b1}};

    regs_t regs_d, regs_q;
    logic          tick, wrap, reach, restart;
    logic [CW-1:0] top_val;
    logic [1:0]    mode_a, mode_b;

    assign restart = wr_en && (wr_addr == ADDR_CTRL) && (wr_data[2:0] != regs_q.sel);
    assign top_val = regs_q.top_sel ? regs_q.act_a[CW-1:0] : MAX_VAL;
    assign mode_a  = regs_q.mode_a;
    assign mode_b  = regs_q.mode_b;

    always_comb begin
        regs_d = regs_q;
        if (wrap) begin
            regs_d.act_a = regs_q.buf_a;
            regs_d.act_b = regs_q.buf_b;
        end
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: begin
                    regs_d.sel     = wr_data[2:0];
                    regs_d.top_sel = wr_data[3];
                end
                ADDR_MODE: begin
                    regs_d.mode_a = wr_data[1:0];
                    regs_d.mode_b = wr_data[3:2];
                end
                ADDR_CMP_A: regs_d.buf_a = wr_data;
                ADDR_CMP_B: regs_d.buf_b = wr_data;
                ADDR_CLR:   if (wr_data[0]) regs_d.flag = 1'b0;
                default: ;
            endcase
        end
        if (reach) regs_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    pwm8_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .sel(regs_q.sel), .restart(restart), .tick(tick)
    );

    pwm8_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .top_val(top_val),
        .cnt(cnt), .wrap(wrap), .reach(reach)
    );

    pwm8_channel #(.CW(CW), .HAS_TOGGLE(1'b1)) u_ch_a (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .cnt(cnt),
        .cmp(regs_q.act_a[CW-1:0]), .mode(mode_a), .wave(out_a)
    );

    pwm8_channel #(.CW(CW), .HAS_TOGGLE(1'b0)) u_ch_b (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .cnt(cnt),
        .cmp(regs_q.act_b[CW-1:0]), .mode(mode_b), .wave(out_b)
    );

    assign ovf_flag = regs_q.flag;
endmodule

// File: rtl/pwm8_timer_chk.sv
module pwm8_timer_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic [7:0]    wr_data,
    input logic          tick,
    input logic [CW-1:0] top_val,
    input logic [CW-1:0] cnt,
    input logic          out_a,
    input logic          out_b,
    input logic          ovf_flag,
    input logic [1:0]    mode_a,
    input logic [1:0]    mode_b
);
    p_wrap_to_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == top_val) |=> (cnt == '0));

    p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    p_noninv_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_a == 2'd2 && cnt == top_val) |=> out_a);

    p_inv_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_a == 2'd3 && cnt == top_val) |=> !out_a);

    p_b_toggle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b == 2'd1) |=> !out_b);

    p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a == 2'd0) |=> !out_a);

    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != top_val && (cnt + CW'(1)) == top_val) |=> ovf_flag);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(wr_en && wr_addr == 3'd4 && wr_data[0])) |=> ovf_flag);
endmodule

bind pwm8_timer pwm8_timer_chk #(.CW(CW)) u_chk (.*);

// File: tb/pwm8_timer_tb.sv
module pwm8_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] cnt;
    logic       out_a, out_b, ovf_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm8_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt(cnt), .out_a(out_a), .out_b(out_b), .ovf_flag(ovf_flag)
    );

    // reference state, built from the requirements
    logic [2:0] m_sel;
    logic       m_tsel, m_oa, m_ob, m_flag;
    logic [1:0] m_ma, m_mb;
    logic [7:0] m_bufa, m_bufb, m_acta, m_actb, m_cnt, m_top, m_next;
    logic [9:0] m_pre;
    logic       m_tk, m_wrap, m_reach, m_ma_hit, m_mb_hit;

    function automatic logic [9:0] lim_of(input logic [2:0] s);
        case (s)
            3'd2: return 10'd7;
            3'd3: return 10'd31;
            3'd4: return 10'd63;
            3'd5: return 10'd127;
            3'd6: return 10'd255;
            3'd7: return 10'd1023;
            default: return 10'd0;
        endcase
    endfunction

    function automatic logic next_wave(input logic [1:0] md, input bit tog, input logic cur,
                                       input logic tk, input logic wr, input logic hit);
        case (md)
            2'd0: return 1'b0;
            2'd1: return tog ? ((tk && hit) ? ~cur : cur) : 1'b0;
            2'd2: return (tk && wr) ? 1'b1 : ((tk && hit) ? 1'b0 : cur);
            default: return (tk && wr) ? 1'b0 : ((tk && hit) ? 1'b1 : cur);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_tsel = 0; m_oa = 0; m_ob = 0; m_flag = 0; m_ma = 0; m_mb = 0;
            m_bufa = 0; m_bufb = 0; m_acta = 0; m_actb = 0; m_cnt = 0; m_pre = 0;
        end else begin
            m_tk     = (m_sel != 0) && (m_pre == lim_of(m_sel));
            m_top    = m_tsel ? m_acta : 8'hFF;
            m_wrap   = m_tk && (m_cnt == m_top);
            m_next   = (m_cnt == m_top) ? 8'd0 : m_cnt + 8'd1;
            m_reach  = m_tk && (m_next == m_top);
            m_ma_hit = (m_cnt == m_acta);
            m_mb_hit = (m_cnt == m_actb);
            m_oa = next_wave(m_ma, 1'b1, m_oa, m_tk, m_wrap, m_ma_hit);
            m_ob = next_wave(m_mb, 1'b0, m_ob, m_tk, m_wrap, m_mb_hit);
            if ((wr_en && wr_addr == 3'd0 && wr_data[2:0] != m_sel) || m_sel == 0 || m_tk)
                m_pre = 0;
            else
                m_pre = m_pre + 10'd1;
            if (m_tk) m_cnt = m_next;
            if (m_wrap) begin m_acta = m_bufa; m_actb = m_bufb; end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_sel = wr_data[2:0]; m_tsel = wr_data[3]; end
                    3'd1: begin m_ma = wr_data[1:0]; m_mb = wr_data[3:2]; end
                    3'd2: m_bufa = wr_data;
                    3'd3: m_bufb = wr_data;
                    3'd4: if (wr_data[0]) m_flag = 1'b0;
                    default: ;
                endcase
            end
            if (m_reach) m_flag = 1'b1;
        end
    end

    // continuous comparison against the reference at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (cnt !== m_cnt) begin
                errors++; $display("FAIL R1 cnt actual %0d expected %0d", cnt, m_cnt);
            end
            checks++;
            if (out_a !== m_oa) begin
                errors++; $display("FAIL R4 out_a actual %0b expected %0b (mode %0d)", out_a, m_oa, m_ma);
            end
            checks++;
            if (out_b !== m_ob) begin
                errors++; $display("FAIL R5 out_b actual %0b expected %0b (mode %0d)", out_b, m_ob, m_mb);
            end
            checks++;
            if (ovf_flag !== m_flag) begin
                errors++; $display("FAIL R9 flag actual %0b expected %0b", ovf_flag, m_flag);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int hi, mx, gap;
        logic [7:0] prev;
        logic prev_a;
        void'($urandom(32'd2024));
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset cnt", cnt, 0);
        chk("R1 reset out_a", out_a, 0);
        chk("R9 reset flag", ovf_flag, 0);
        idle(20);
        chk("R1 stopped with select 0", cnt, 0);

        // R10: compare 0 spike, top 0xFF
        wr(3'd1, 8'h0A);           // A mode 2, B mode 2
        wr(3'd2, 8'd0);
        wr(3'd0, 8'h01);
        idle(300);
        hi = 0;
        for (int i = 0; i < 256; i++) begin @(negedge clk); hi += out_a; end
        chk("R10 spike high cycles", hi, 1);
        // R10: compare 0xFF constant high
        wr(3'd2, 8'hFF);
        idle(300);
        hi = 0;
        for (int i = 0; i < 256; i++) begin @(negedge clk); hi += out_a; end
        chk("R10 max compare high cycles", hi, 256);

        // R11: writes to unused addresses change nothing
        wr(3'd5, 8'hFF); wr(3'd6, 8'h00); wr(3'd7, 8'h5A);
        hi = 0;
        for (int i = 0; i < 256; i++) begin @(negedge clk); hi += out_a; end
        chk("R11 unused address no effect", hi, 256);

        // R5: inverting with compare 0xFF gives constant low
        wr(3'd1, 8'h03);
        idle(300);
        hi = 0;
        for (int i = 0; i < 256; i++) begin @(negedge clk); hi += out_a; end
        chk("R5 inverting max compare high cycles", hi, 0);

        // R2 and R8: channel-A top, buffered new compare
        wr(3'd1, 8'h02);
        wr(3'd2, 8'd50);
        wr(3'd0, 8'h09);
        idle(600);
        wait (cnt == 8'd20); @(negedge clk);
        wr(3'd2, 8'd5);
        mx = 0;
        for (int i = 0; i < 200 && cnt != 0; i++) begin
            if (cnt > mx) mx = cnt;
            @(negedge clk);
        end
        chk("R8 old compare used until wrap", mx, 50);
        @(negedge clk);
        mx = 0;
        for (int i = 0; i < 40; i++) begin if (cnt > mx) mx = cnt; @(negedge clk); end
        chk("R2 top follows compare A", mx, 5);

        // R6: toggle at half tick rate
        wr(3'd2, 8'd0);
        wr(3'd1, 8'h05);           // A toggle, B code 1
        idle(20);
        prev_a = out_a;
        hi = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (out_a != prev_a) hi++;
            prev_a = out_a;
        end
        chk("R6 toggle every tick", hi, 16);
        chk("R6 channel B code 1 low", out_b, 0);

        // R7: off mode
        wr(3'd1, 8'h00);
        idle(3);
        chk("R7 off mode low", out_a, 0);

        // R9: clear then flag again
        wr(3'd0, 8'h01);
        wr(3'd4, 8'h01);
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h01);
        @(negedge clk);
        chk("R9 flag cleared", ovf_flag, 0);
        wr(3'd4, 8'h00);
        chk("R9 clear needs bit 0", ovf_flag, 0);

        // R3: prescaler period 8 and stop
        wr(3'd0, 8'h02);
        prev = cnt;
        while (cnt == prev) @(negedge clk);
        prev = cnt; gap = 0;
        while (cnt == prev && gap < 100) begin @(negedge clk); gap++; end
        chk("R3 divide by 8 step", gap, 8);
        wr(3'd0, 8'h03);
        prev = cnt; gap = 0;
        while (cnt == prev && gap < 200) begin @(negedge clk); gap++; end
        prev = cnt; gap = 0;
        while (cnt == prev && gap < 200) begin @(negedge clk); gap++; end
        chk("R3 divide by 32 step", gap, 32);
        wr(3'd0, 8'h00);
        prev = cnt;
        idle(100);
        chk("R3 select 0 stops", cnt, prev);

        // random phase checked by the reference every cycle
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 6) == 0) begin
                logic [2:0] a;
                logic [7:0] d;
                a = 3'($urandom % 6);
                d = 8'($urandom);
                if (a == 3'd0 && d[2:0] > 3'd2) d[2:0] = 3'd1;
                wr(a, d);
            end else begin
                @(negedge clk);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule